// File: doc/BRIEF.md
# PHY Loopback Mode Controller

This block sits in the parallel-word datapath of a 10G PHY and decides, cycle by cycle, what leaves the chip on the line transmit word and on the four host receive lanes. Six loopback points are modelled, four on the system side and two on the network side. System-side loopbacks send the host transmit lanes back to the host. Network-side loopbacks send the received line word back to the line. Each mode has its own enable bit and its own data-override bit. The override decides whether the real data or a fixed substitute (a fill pattern toward the line, idle characters toward the host) is sent.

A separate lane loopback copies one chosen host transmit lane, or the recovered clock level of that lane, onto host receive lane 3. All settings sit in a 16-bit control word inside the block. That word is written through a masked write port, so single bits can be changed without touching their neighbours. Every output is a register. If more than one of the six loopbacks is enabled at once, a fixed priority chooses the mode that applies and a sticky flag records the conflict.

Top module: `lpbk_steer`

## Requirements
- R1: While a system-side loopback decides the mode (control bit 0 PMA, bit 1 WIS, bit 2 PCS, bit 3 XGXS) and lane loopback is off, each host receive lane carries the data and control flag of the same host transmit lane. Lane i sits in data bits [8i+7:8i] and control bit i.
- R2: In PMA system loopback with its override (bit 6) clear, the line transmit word is all zeros.
- R3: In XGXS system loopback with its override (bit 9) clear, the line transmit word is all ones.
- R4: In WIS system loopback (override bit 7 clear) or PCS system loopback (override bit 8 clear), the line transmit word is 0x00FF.
- R5: When the override bit of the system loopback in control is set, the line transmit word is the normal transmit word.
- R6: After reset, the control word is 0x0C00: every system override is 0, and the network overrides (bit 10 PMA, bit 11 XGXS) are 1. Enabling a mode with a masked write that leaves the override bits alone therefore shows the fill pattern (system) or idle characters (network).
- R7: In a network loopback (bit 4 PMA, bit 5 XGXS), the line transmit word is the received line word. The host receive lanes carry the normal host receive data when that mode's override is clear. When the override is set, each lane carries the idle character 0x07 with its control flag set.
- R8: With lane loopback on (bit 12), host receive lane 3 carries the data and control flag of the host transmit lane selected by bits 14:13, and lanes 0 to 2 are unchanged.
- R9: With lane loopback on and bit 15 set, every data bit of host receive lane 3 equals the recovered-clock level of the selected lane, and its control flag is 0.
- R10: When several enables are set, only one mode applies, in the order PMA network, XGXS network, PMA system, WIS system, PCS system, XGXS system. A multiple-loopback flag rises on the next clock edge and stays set until reset.
- R11: With no loopback enabled, the line transmit word is the normal transmit word and the host receive lanes are the normal host receive lanes.
- R12: Outputs are zero during reset. Data inputs show on the outputs after exactly one clock. A control write captured at edge E governs the outputs registered at edge E+1 and later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control write strobe |
| cfg_wr_mask | input | 16 | Bits of the control word to update |
| cfg_wr_data | input | 16 | New values for the masked bits |
| tx_word | input | LINE_W | Normal transmit word toward the line |
| rx_line_word | input | LINE_W | Received line word |
| htx_data | input | 4*LANE_W | Host transmit lane data |
| htx_ctrl | input | 4 | Host transmit lane control flags |
| htx_rclk | input | 4 | Recovered clock level of each host transmit lane |
| rx_host_data | input | 4*LANE_W | Normal host receive lane data |
| rx_host_ctrl | input | 4 | Normal host receive lane control flags |
| line_tx_word | output | LINE_W | Registered line transmit word |
| hrx_data | output | 4*LANE_W | Registered host receive lane data |
| hrx_ctrl | output | 4 | Registered host receive lane control flags |
| multi_lb | output | 1 | Sticky multiple-loopback flag |

## Verification
The bench builds the block with its default parameters: a 16-bit line word, 8-bit lanes and the idle character 0x07. At that line width the alternating-byte fill is exactly 0x00FF, and idle lanes can be told apart from both host sources. Distinct constant data on every input shows which source drives each output in every mode, for each override setting and for each lane select. Masked writes right after reset show the default override values through the outputs. The flag and priority are checked with overlapping enables.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

    localparam int NLANES = 4;
    localparam int LSEL_W = 2;
    localparam int CTRL_W = 16;
    localparam int NMODES = 6;

    // Reset value: network overrides set, everything else clear.
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0C00;

    // Field order from bit 15 down to bit 0.
    typedef struct packed {
        logic              lane_clk;
        logic [LSEL_W-1:0] lane_sel;
        logic              lane_en;
        logic              xnet_ovr;
        logic              pnet_ovr;
        logic              xsys_ovr;
        logic              pcs_ovr;
        logic              wis_ovr;
        logic              psys_ovr;
        logic              xnet_en;
        logic              pnet_en;
        logic              xsys_en;
        logic              pcs_en;
        logic              wis_en;
        logic              psys_en;
    } lb_ctrl_t;

    typedef enum logic [2:0] {
        LB_NONE, LB_PMA_NET, LB_XGXS_NET, LB_PMA_SYS,
        LB_WIS_SYS, LB_PCS_SYS, LB_XGXS_SYS
    } lb_mode_e;

    typedef enum logic [1:0] { FILL_ZERO, FILL_ONE, FILL_ALT } fill_e;
    typedef enum logic [1:0] { LSRC_TX, LSRC_FILL, LSRC_RXLINE } line_src_e;
    typedef enum logic [1:0] { HSRC_NORMAL, HSRC_HOST_TX, HSRC_IDLE } host_src_e;

    typedef struct packed {
        lb_mode_e  mode;
        line_src_e line_src;
        fill_e     fill;
        host_src_e host_src;
    } lb_plan_t;

    function automatic logic [NMODES-1:0] mode_enables(lb_ctrl_t c);
        return {c.xnet_en, c.pnet_en, c.xsys_en, c.pcs_en, c.wis_en, c.psys_en};
    endfunction

    function automatic logic sys_plan(lb_mode_e m, logic ovr, fill_e f,
                                      output lb_plan_t p);
        p.mode     = m;
        p.host_src = HSRC_HOST_TX;
        p.line_src = ovr ? LSRC_TX : LSRC_FILL;
        p.fill     = f;
        return 1'b1;
    endfunction

endpackage

// File: rtl/lpbk_ctrl_reg.sv
module lpbk_ctrl_reg
    import lpbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_mask,
    input  logic [CTRL_W-1:0] wr_data,
    output lb_ctrl_t          ctrl_q
);
    logic [CTRL_W-1:0] bits_q;

    for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[b] <= CTRL_RST[b];
            else if (wr_en && wr_mask[b])
                bits_q[b] <= wr_data[b];
        end
    end

    assign ctrl_q = lb_ctrl_t'(bits_q);
endmodule

// File: rtl/lpbk_arbiter.sv
module lpbk_arbiter
    import lpbk_pkg::*;
(
    input  lb_ctrl_t ctrl,
    output lb_plan_t plan,
    output logic     multi
);
    logic unused_ok;

    always_comb begin
        plan.mode     = LB_NONE;
        plan.line_src = LSRC_TX;
        plan.fill     = FILL_ZERO;
        plan.host_src = HSRC_NORMAL;
        unused_ok     = 1'b1;
        if (ctrl.pnet_en) begin
            plan.mode     = LB_PMA_NET;
            plan.line_src = LSRC_RXLINE;
            plan.host_src = ctrl.pnet_ovr ? HSRC_IDLE : HSRC_NORMAL;
        end else if (ctrl.xnet_en) begin
            plan.mode     = LB_XGXS_NET;
            plan.line_src = LSRC_RXLINE;
            plan.host_src = ctrl.xnet_ovr ? HSRC_IDLE : HSRC_NORMAL;
        end else if (ctrl.psys_en) begin
            unused_ok = sys_plan(LB_PMA_SYS, ctrl.psys_ovr, FILL_ZERO, plan);
        end else if (ctrl.wis_en) begin
            unused_ok = sys_plan(LB_WIS_SYS, ctrl.wis_ovr, FILL_ALT, plan);
        end else if (ctrl.pcs_en) begin
            unused_ok = sys_plan(LB_PCS_SYS, ctrl.pcs_ovr, FILL_ALT, plan);
        end else if (ctrl.xsys_en) begin
            unused_ok = sys_plan(LB_XGXS_SYS, ctrl.xsys_ovr, FILL_ONE, plan);
        end
    end

    assign multi = ($countones(mode_enables(ctrl)) > 1) && unused_ok;
endmodule

// File: rtl/lpbk_fill.sv
module lpbk_fill
    import lpbk_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  fill_e             sel,
    output logic [LINE_W-1:0] word
);
    logic [LINE_W-1:0] alt_pat;

    // Low byte of every 16-bit group ones, high byte zeros.
    for (genvar i = 0; i < LINE_W; i++) begin : g_alt
        assign alt_pat[i] = ((i / 8) % 2) == 0;
    end

    always_comb begin
        unique case (sel)
            FILL_ONE: word = '1;
            FILL_ALT: word = alt_pat;
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/lpbk_lane_route.sv
module lpbk_lane_route
    import lpbk_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [NLANES*LANE_W-1:0] base_data,
    input  logic [NLANES-1:0]        base_ctrl,
    input  logic [NLANES*LANE_W-1:0] src_data,
    input  logic [NLANES-1:0]        src_ctrl,
    input  logic [NLANES-1:0]        src_rclk,
    input  logic                     lane_en,
    input  logic [LSEL_W-1:0]        lane_sel,
    input  logic                     lane_clk,
    output logic [NLANES*LANE_W-1:0] out_data,
    output logic [NLANES-1:0]        out_ctrl
);
    localparam int LAST = NLANES - 1;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        if (l == LAST) begin : g_tap
            logic [LANE_W-1:0] pick_d;
            logic              pick_c;
            always_comb begin
                if (lane_clk) begin
                    pick_d = {LANE_W{src_rclk[lane_sel]}};
                    pick_c = 1'b0;
                end else begin
                    pick_d = src_data[lane_sel*LANE_W +: LANE_W];
                    pick_c = src_ctrl[lane_sel];
                end
            end
            assign out_data[l*LANE_W +: LANE_W] = lane_en ? pick_d : base_data[l*LANE_W +: LANE_W];
            assign out_ctrl[l] = lane_en ? pick_c : base_ctrl[l];
        end else begin : g_pass
            assign out_data[l*LANE_W +: LANE_W] = base_data[l*LANE_W +: LANE_W];
            assign out_ctrl[l] = base_ctrl[l];
        end
    end
endmodule

// File: rtl/lpbk_steer.sv
module lpbk_steer
    import lpbk_pkg::*;
#(
    parameter int                LINE_W    = 16,
    parameter int                LANE_W    = 8,
    parameter logic [LANE_W-1:0] IDLE_CHAR = 8'h07,
    parameter logic              IDLE_FLAG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr_en,
    input  logic [CTRL_W-1:0]        cfg_wr_mask,
    input  logic [CTRL_W-1:0]        cfg_wr_data,
    input  logic [LINE_W-1:0]        tx_word,
    input  logic [LINE_W-1:0]        rx_line_word,
    input  logic [NLANES*LANE_W-1:0] htx_data,
    input  logic [NLANES-1:0]        htx_ctrl,
    input  logic [NLANES-1:0]        htx_rclk,
    input  logic [NLANES*LANE_W-1:0] rx_host_data,
    input  logic [NLANES-1:0]        rx_host_ctrl,
    output logic [LINE_W-1:0]        line_tx_word,
    output logic [NLANES*LANE_W-1:0] hrx_data,
    output logic [NLANES-1:0]        hrx_ctrl,
    output logic                     multi_lb
);
    localparam int HOST_W = NLANES * LANE_W;

    lb_ctrl_t          ctrl_q;
    lb_plan_t          plan;
    logic              multi_now;
    logic [LINE_W-1:0] fill_word;
    logic [LINE_W-1:0] line_nxt;
    logic [HOST_W-1:0] base_d, host_d_nxt;
    logic [NLANES-1:0] base_c, host_c_nxt;

    lpbk_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en),
        .wr_mask(cfg_wr_mask), .wr_data(cfg_wr_data), .ctrl_q(ctrl_q)
    );

    lpbk_arbiter u_arb (.ctrl(ctrl_q), .plan(plan), .multi(multi_now));

    lpbk_fill #(.LINE_W(LINE_W)) u_fill (.sel(plan.fill), .word(fill_word));

    always_comb begin
        unique case (plan.line_src)
            LSRC_FILL:   line_nxt = fill_word;
            LSRC_RXLINE: line_nxt = rx_line_word;
            default:     line_nxt = tx_word;
        endcase
    end

    always_comb begin
        unique case (plan.host_src)
            HSRC_HOST_TX: begin base_d = htx_data; base_c = htx_ctrl; end
            HSRC_IDLE:    begin base_d = {NLANES{IDLE_CHAR}}; base_c = {NLANES{IDLE_FLAG}}; end
            default:      begin base_d = rx_host_data; base_c = rx_host_ctrl; end
        endcase
    end

    lpbk_lane_route #(.LANE_W(LANE_W)) u_route (
        .base_data(base_d), .base_ctrl(base_c),
        .src_data(htx_data), .src_ctrl(htx_ctrl), .src_rclk(htx_rclk),
        .lane_en(ctrl_q.lane_en), .lane_sel(ctrl_q.lane_sel), .lane_clk(ctrl_q.lane_clk),
        .out_data(host_d_nxt), .out_ctrl(host_c_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_tx_word <= '0;
            hrx_data     <= '0;
            hrx_ctrl     <= '0;
            multi_lb     <= 1'b0;
        end else begin
            line_tx_word <= line_nxt;
            hrx_data     <= host_d_nxt;
            hrx_ctrl     <= host_c_nxt;
            multi_lb     <= multi_lb | multi_now;
        end
    end
endmodule

// File: rtl/lpbk_steer_chk.sv
module lpbk_steer_chk
    import lpbk_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_wr_en,
    input lb_ctrl_t                 ctrl_q,
    input logic [LINE_W-1:0]        rx_line_word,
    input logic [NLANES*LANE_W-1:0] htx_data,
    input logic [LINE_W-1:0]        line_tx_word,
    input logic [NLANES*LANE_W-1:0] hrx_data,
    input logic [NLANES-1:0]        hrx_ctrl,
    input logic                     multi_lb
);
    logic sys_on, net_on;
    assign net_on = ctrl_q.pnet_en | ctrl_q.xnet_en;
    assign sys_on = ctrl_q.psys_en | ctrl_q.wis_en | ctrl_q.pcs_en | ctrl_q.xsys_en;

    a_r1_sys_return: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && sys_on && !net_on && !ctrl_q.lane_en) |=> hrx_data == $past(htx_data));

    a_r2_pma_zero: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && ctrl_q.psys_en && !net_on && !ctrl_q.psys_ovr) |=> line_tx_word == '0);

    a_r3_xgxs_ones: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && ctrl_q.xsys_en && !net_on && !ctrl_q.psys_en && !ctrl_q.wis_en
         && !ctrl_q.pcs_en && !ctrl_q.xsys_ovr) |=> line_tx_word == '1);

    a_r7_net_line: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && net_on) |=> line_tx_word == $past(rx_line_word));

    a_r9_clk_flag: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && ctrl_q.lane_en && ctrl_q.lane_clk) |=> !hrx_ctrl[NLANES-1]);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        multi_lb |=> multi_lb);

    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && $countones(mode_enables(ctrl_q)) > 1) |=> multi_lb);
endmodule

bind lpbk_steer lpbk_steer_chk #(.LINE_W(LINE_W), .LANE_W(LANE_W)) i_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .ctrl_q(ctrl_q),
    .rx_line_word(rx_line_word), .htx_data(htx_data),
    .line_tx_word(line_tx_word), .hrx_data(hrx_data), .hrx_ctrl(hrx_ctrl),
    .multi_lb(multi_lb)
);

// File: tb/test_lpbk_steer.sv
module test_lpbk_steer;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_mask = '0, cfg_wr_data = '0;
    logic [15:0] tx_word = 16'h3C5A, rx_line_word = 16'h9617;
    logic [31:0] htx_data = 32'h11223344;
    logic [3:0]  htx_ctrl = 4'b0101, htx_rclk = 4'b1010;
    logic [31:0] rx_host_data = 32'hAABBCCDD;
    logic [3:0]  rx_host_ctrl = 4'b0010;
    logic [15:0] line_tx_word;
    logic [31:0] hrx_data;
    logic [3:0]  hrx_ctrl;
    logic        multi_lb;

    lpbk_steer i_lpbk_steer (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_mask(cfg_wr_mask),
        .cfg_wr_data(cfg_wr_data), .tx_word(tx_word), .rx_line_word(rx_line_word),
        .htx_data(htx_data), .htx_ctrl(htx_ctrl), .htx_rclk(htx_rclk),
        .rx_host_data(rx_host_data), .rx_host_ctrl(rx_host_ctrl),
        .line_tx_word(line_tx_word), .hrx_data(hrx_data), .hrx_ctrl(hrx_ctrl),
        .multi_lb(multi_lb)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected host image: 0 normal, 1 host transmit, 2 idle.
    function automatic logic [35:0] host_exp(input logic [1:0] src);
        case (src)
            2'd1:    return {4'b0101, 32'h11223344};
            2'd2:    return {4'b1111, 32'h07070707};
            default: return {4'b0010, 32'hAABBCCDD};
        endcase
    endfunction

    // Write at edge E, outputs reflect it after E+1; returns at the following negedge.
    task automatic cfg_write(input logic [15:0] mask, input logic [15:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_mask = mask; cfg_wr_data = data;
        @(posedge clk);
        #1 cfg_wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    typedef struct packed {
        logic [15:0] ctl;
        logic [15:0] line;
        logic [1:0]  src;
        logic        flag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h3C5A, 2'd0, 1'b0},   // R11 no loopback
        '{16'h0001, 16'h0000, 2'd1, 1'b0},   // R2 R1 PMA system
        '{16'h0041, 16'h3C5A, 2'd1, 1'b0},   // R5 PMA override
        '{16'h0002, 16'h00FF, 2'd1, 1'b0},   // R4 WIS
        '{16'h0082, 16'h3C5A, 2'd1, 1'b0},   // R5 WIS override
        '{16'h0004, 16'h00FF, 2'd1, 1'b0},   // R4 PCS
        '{16'h0104, 16'h3C5A, 2'd1, 1'b0},   // R5 PCS override
        '{16'h0008, 16'hFFFF, 2'd1, 1'b0},   // R3 XGXS system
        '{16'h0208, 16'h3C5A, 2'd1, 1'b0},   // R5 XGXS override
        '{16'h0010, 16'h9617, 2'd0, 1'b0},   // R7 PMA network data
        '{16'h0410, 16'h9617, 2'd2, 1'b0},   // R7 PMA network idle
        '{16'h0020, 16'h9617, 2'd0, 1'b0},   // R7 XGXS network data
        '{16'h0820, 16'h9617, 2'd2, 1'b0},   // R7 XGXS network idle
        '{16'h0009, 16'h0000, 2'd1, 1'b1},   // R10 PMA over XGXS system
        '{16'h0106, 16'h00FF, 2'd1, 1'b1},   // R10 WIS over PCS
        '{16'h0831, 16'h9617, 2'd0, 1'b1},   // R10 PMA net over XGXS net
        '{16'h000C, 16'h00FF, 2'd1, 1'b1}    // R10 PCS over XGXS system
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [35:0] he;
        // R12 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 reset line", line_tx_word, 0);
        check("R12 reset host", {hrx_ctrl, hrx_data}, 0);
        check("R12 reset flag", multi_lb, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11 idle line", line_tx_word, 16'h3C5A);
        check("R11 idle host", {hrx_ctrl, hrx_data}, host_exp(2'd0));

        // R6 override defaults, touching only enable bits
        cfg_write(16'h0001, 16'h0001);
        check("R6 sys override default", line_tx_word, 16'h0000);
        cfg_write(16'h0011, 16'h0010);
        check("R6 net override default", {hrx_ctrl, hrx_data}, host_exp(2'd2));
        cfg_write(16'h0018, 16'h0008);
        check("R6 xgxs sys override default", line_tx_word, 16'hFFFF);
        check("R10 no flag on single modes", multi_lb, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            cfg_write(16'hFFFF, VECS[v].ctl);
            check($sformatf("R2-R5/R7/R10 vec%0d line", v), line_tx_word, VECS[v].line);
            check($sformatf("R1/R7/R11 vec%0d host", v), {hrx_ctrl, hrx_data}, host_exp(VECS[v].src));
            check($sformatf("R10 vec%0d flag", v), multi_lb, VECS[v].flag);
        end

        // R8 lane route, R9 clock select
        do_reset();
        for (int s = 0; s < 4; s++) begin
            cfg_write(16'hFFFF, 16'h1000 | 16'(s << 13));
            check($sformatf("R8 lane sel %0d data", s), hrx_data,
                  {htx_data[s*8 +: 8], 24'hBBCCDD});
            check($sformatf("R8 lane sel %0d ctrl", s), hrx_ctrl, {htx_ctrl[s], 3'b010});
            cfg_write(16'hFFFF, 16'h9000 | 16'(s << 13));
            check($sformatf("R9 clk sel %0d data", s), hrx_data,
                  {{8{htx_rclk[s]}}, 24'hBBCCDD});
            check($sformatf("R9 clk sel %0d ctrl", s), hrx_ctrl, 4'b0010);
        end
        check("R10 flag cleared by reset", multi_lb, 0);

        // R12 latency of data and control
        cfg_write(16'hFFFF, 16'h0000);
        tx_word = 16'h1234;
        @(posedge clk); @(negedge clk);
        check("R12 data one cycle", line_tx_word, 16'h1234);
        tx_word = 16'h4321;
        #2 check("R12 data held before edge", line_tx_word, 16'h1234);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_mask = 16'hFFFF; cfg_wr_data = 16'h0001;
        @(posedge clk); #1 cfg_wr_en = 1'b0;
        @(negedge clk);
        check("R12 mode not yet applied", line_tx_word, 16'h4321);
        @(negedge clk);
        check("R12 mode applied next edge", line_tx_word, 16'h0000);
        he = host_exp(2'd1);
        check("R1 host after mode change", {hrx_ctrl, hrx_data}, he);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule